// File: doc/BRIEF.md
# Integer Square Root Peripheral

This block computes the floor of the square root of an unsigned integer held in a small register file. Software writes a 64-bit argument as two 32-bit words and sets a width-select bit in a control word. Any write to the control word or to either argument word starts a new computation. A busy flag stays high until the 32-bit root is stored in the root register.

When the width bit is clear, only the low 32 bits of the argument are used. The upper word is masked to zero before the computation starts. When the bit is set, all 64 bits take part. The engine uses the power-of-four trial-subtraction method and handles one bit pair per clock. It first jumps directly to the highest non-zero bit pair of the argument, so small arguments finish early.

The controller has four states:
- `ST_IDLE`: waiting.
- `ST_LOAD`: captures the masked argument and finds the starting bit pair.
- `ST_STEP`: one trial subtraction per cycle.
- `ST_STORE`: writes the root register and drops busy.

The transitions are:
- IDLE→LOAD on a start write.
- LOAD→STEP for a non-zero argument.
- LOAD→STORE for a zero argument.
- STEP→STEP while lower pairs remain.
- STEP→STORE after the lowest pair.
- STORE→IDLE.

A start write in any state moves the controller to LOAD, which discards the work in progress.

Top module: `sqrt_unit`

## Requirements
- R1: After reset the control word (address 0) reads 0, the root register (address 3) reads 0 and `busy` is low.
- R2: A write to address 0 (control), 1 (argument low word) or 2 (argument high word) makes `busy` high at the next clock edge, and bit 15 of the control word reads 1 while busy.
- R3: When `busy` falls, the root register holds the largest value r with r*r not above the effective argument.
- R4: With control bit 0 clear, the argument high word has no effect on the root or on the latency.
- R5: With control bit 0 set, the full 64-bit argument is used, including the largest input 2^64-1 (root 0xFFFFFFFF).
- R6: An effective argument of zero gives root 0, and `busy` falls 2 clock edges after the starting write.
- R7: For a non-zero effective argument whose highest non-zero bit pair has index k (bits 2k+1:2k), `busy` falls k+3 clock edges after the starting write.
- R8: A start write while busy abandons the running computation. Only one completion follows, and it carries the newest argument and mode.
- R9: Addresses 1 and 2 read back the argument words. Control bit 0 reads back as written. Bit 15 of the control word cannot be set by a write.
- R10: The root register keeps its previous value during a computation and changes only at completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 argument low, 2 argument high, 3 root (writes ignored) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 32 | Read data, combinational from the registers |
| busy | output | 1 | High from a start write until the root is stored |

## Verification
The arguments cover four groups:
- Zero, one and small perfect squares and their neighbours, which separate off-by-one flooring errors from correct flooring.
- Values whose top bit pair lies in different positions, so the measured latency exposes whether leading-zero pairs are skipped correctly.
- Narrow-mode values with a non-zero high word, alongside the same values in wide mode, which show whether masking is done.
- The 32-bit and 64-bit extremes, which stress the widest trial sums.

A restart sequence of three back-to-back writes during a long computation shows whether a stale result or a duplicate completion leaks out.

// File: rtl/sqrt_pkg.sv
package sqrt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_STEP  = 2'd2,
        ST_STORE = 2'd3
    } sqrt_state_e;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_ARG_LO = 2'd1;
    localparam logic [1:0] ADDR_ARG_HI = 2'd2;
    localparam logic [1:0] ADDR_ROOT   = 2'd3;

    localparam int CTRL_WIDE_BIT = 0;
    localparam int CTRL_BUSY_BIT = 15;

endpackage

// File: rtl/sqrt_lead_pair.sv
// Finds the index of the highest non-zero bit pair of the operand; that pair
// gives the largest power of four not above the operand.
module sqrt_lead_pair #(
    parameter int OP_W = 64,
    localparam int PAIRS = OP_W / 2,
    localparam int IDX_W = $clog2(PAIRS)
) (
    input  logic [OP_W-1:0]  op,
    output logic [IDX_W-1:0] top_idx,
    output logic             any_set
);

    logic [PAIRS-1:0] pair_hit;

    genvar p;
    generate
        for (p = 0; p < PAIRS; p++) begin : g_pair
            assign pair_hit[p] = |op[2*p+1 -: 2];
        end
    endgenerate

    always_comb begin
        top_idx = '0;
        for (int i = 0; i < PAIRS; i++) begin
            if (pair_hit[i]) top_idx = IDX_W'(i);
        end
    end

    assign any_set = |pair_hit;

endmodule

// File: rtl/sqrt_step.sv
// One trial subtraction for the bit pair selected by idx.
module sqrt_step #(
    parameter int OP_W = 64,
    localparam int IDX_W = $clog2(OP_W / 2)
) (
    input  logic [OP_W-1:0]  rem_in,
    input  logic [OP_W-1:0]  acc_in,
    input  logic [IDX_W-1:0] idx,
    output logic [OP_W-1:0]  rem_out,
    output logic [OP_W-1:0]  acc_out
);

    logic [OP_W-1:0] trial_bit;
    logic [OP_W:0]   trial_sum;

    always_comb begin
        trial_bit = {{(OP_W-1){1'b0}}, 1'b1} << {idx, 1'b0};
        trial_sum = {1'b0, acc_in} + {1'b0, trial_bit};
        if ({1'b0, rem_in} >= trial_sum) begin
            rem_out = rem_in - trial_sum[OP_W-1:0];
            acc_out = (acc_in >> 1) + trial_bit;
        end else begin
            rem_out = rem_in;
            acc_out = acc_in >> 1;
        end
    end

endmodule

// File: rtl/sqrt_fsm.sv
module sqrt_fsm
    import sqrt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        op_nz,
    input  logic        last_pair,
    output sqrt_state_e state,
    output logic        load_en,
    output logic        step_en,
    output logic        store_en,
    output logic        busy
);

    sqrt_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_LOAD;
            ST_LOAD:  if (start) state_nx = ST_LOAD;
                      else       state_nx = op_nz ? ST_STEP : ST_STORE;
            ST_STEP:  if (start)          state_nx = ST_LOAD;
                      else if (last_pair) state_nx = ST_STORE;
            ST_STORE: state_nx = start ? ST_LOAD : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load_en  = 1'b0;
        step_en  = 1'b0;
        store_en = 1'b0;
        busy     = 1'b1;
        unique case (state)
            ST_IDLE:  busy     = 1'b0;
            ST_LOAD:  load_en  = !start;
            ST_STEP:  step_en  = !start;
            ST_STORE: store_en = !start;
            default:  busy     = 1'b0;
        endcase
    end

    // R8: any start write sends the controller back to LOAD
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> state == ST_LOAD);

    // R3: completion returns to idle
    p_store_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE && !start) |=> state == ST_IDLE);

    // R6: a zero operand skips all steps
    p_zero_fast_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && !start && !op_nz) |=> state == ST_STORE);

endmodule

// File: rtl/sqrt_unit.sv
module sqrt_unit
    import sqrt_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [BUS_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [BUS_W-1:0] rd_data,
    output logic             busy
);

    localparam int OP_W  = 2 * BUS_W;
    localparam int RES_W = BUS_W;
    localparam int IDX_W = $clog2(OP_W / 2);

    logic [OP_W-1:0]  arg_q;
    logic             wide_q;
    logic [RES_W-1:0] root_q;
    logic [OP_W-1:0]  rem_q, acc_q, rem_nx, acc_nx, eff_op;
    logic [IDX_W-1:0] idx_q, lead_idx;
    logic             lead_nz, start;
    logic             load_en, step_en, store_en;
    sqrt_state_e      state;

    assign start  = wr_en && (wr_addr != ADDR_ROOT);
    assign eff_op = wide_q ? arg_q : {{BUS_W{1'b0}}, arg_q[BUS_W-1:0]};

    sqrt_lead_pair #(.OP_W(OP_W)) u_lead (
        .op      (eff_op),
        .top_idx (lead_idx),
        .any_set (lead_nz)
    );

    sqrt_step #(.OP_W(OP_W)) u_step (
        .rem_in  (rem_q),
        .acc_in  (acc_q),
        .idx     (idx_q),
        .rem_out (rem_nx),
        .acc_out (acc_nx)
    );

    sqrt_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_nz     (lead_nz),
        .last_pair (idx_q == '0),
        .state     (state),
        .load_en   (load_en),
        .step_en   (step_en),
        .store_en  (store_en),
        .busy      (busy)
    );

    // register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg_q  <= '0;
            wide_q <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_CTRL:   wide_q              <= wr_data[CTRL_WIDE_BIT];
                ADDR_ARG_LO: arg_q[BUS_W-1:0]    <= wr_data;
                ADDR_ARG_HI: arg_q[OP_W-1:BUS_W] <= wr_data;
                default:     ;
            endcase
        end
    end

    // engine datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            acc_q  <= '0;
            idx_q  <= '0;
            root_q <= '0;
        end else begin
            if (load_en) begin
                rem_q <= eff_op;
                acc_q <= '0;
                idx_q <= lead_idx;
            end else if (step_en) begin
                rem_q <= rem_nx;
                acc_q <= acc_nx;
                idx_q <= idx_q - 1'b1;
            end
            if (store_en) root_q <= acc_q[RES_W-1:0];
        end
    end

    // read mux
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CTRL: begin
                rd_data[CTRL_WIDE_BIT] = wide_q;
                rd_data[CTRL_BUSY_BIT] = busy;
            end
            ADDR_ARG_LO: rd_data = arg_q[BUS_W-1:0];
            ADDR_ARG_HI: rd_data = arg_q[OP_W-1:BUS_W];
            ADDR_ROOT:   rd_data = root_q;
            default:     rd_data = '0;
        endcase
    end

    // R2: a start write raises busy
    p_busy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R10: root register moves only on completion
    p_root_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !store_en |=> $stable(root_q));

    // R3: floor property at completion: remainder not above twice the root
    p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        store_en |-> ({1'b0, rem_q} <= {acc_q, 1'b0}));

    // R4: narrow mode clears the upper operand word
    p_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !wide_q) |=> rem_q[OP_W-1:BUS_W] == '0);

    // R7: one bit pair per step, walking downward
    p_pair_walk_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && idx_q != '0) |=> idx_q == IDX_W'($past(idx_q) - 1'b1));

endmodule

// File: tb/sqrt_unit_bench.sv
module sqrt_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd3;
    logic [31:0] rd_data;
    logic        busy;

    int nvec = 0;
    int nmis = 0;
    int cyc  = 0;

    typedef struct {
        logic [31:0] root;
        int          lat;
        int          wcyc;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    logic busy_prev = 1'b0;

    sqrt_unit u_sqrt_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .busy    (busy)
    );

    always #10 clk = ~clk;  // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] expv);
        nvec++;
        if (!ok) begin
            nmis++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] ref_root(input logic [63:0] v);
        logic [63:0] r = '0;
        for (int i = 31; i >= 0; i--) begin
            logic [63:0] c = r | (64'd1 << i);
            if (c * c <= v) r = c;
        end
        return r[31:0];
    endfunction

    function automatic int ref_lat(input logic [63:0] v);
        int k = -1;
        for (int i = 0; i < 32; i++) if (v[2*i +: 2] != 2'b00) k = i;
        return (k < 0) ? 2 : k + 3;
    endfunction

    // called right after a negedge; leaves after the next negedge
    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #2 d = rd_data;
        rd_addr = 2'd3;
    endtask

    task automatic wait_done();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // driver: program argument and mode, push the expected completion
    task automatic run_op(input bit wide, input logic [63:0] arg, input string req);
        logic [63:0] eff;
        logic [31:0] c;
        exp_t e;
        eff = wide ? arg : {32'd0, arg[31:0]};
        bus_wr(2'd1, arg[31:0]);
        bus_wr(2'd2, arg[63:32]);
        bus_wr(2'd0, {31'd0, wide});
        e.root = ref_root(eff);
        e.lat  = ref_lat(eff);
        e.wcyc = cyc;
        e.req  = req;
        exp_q.push_back(e);
        bus_rd(2'd0, c);
        check(c[15] == 1'b1 && busy, "R2 busy after start", {32'd0, c}, 64'h8000);
        wait_done();
    endtask

    // monitor: on each busy fall, compare root and latency
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_prev && !busy) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected completion", {32'd0, rd_data}, 64'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(rd_data == e.root, {e.req, " root"}, {32'd0, rd_data}, {32'd0, e.root});
                    check((cyc - e.wcyc) == e.lat, {e.req, " latency R7"},
                          64'(cyc - e.wcyc), 64'(e.lat));
                end
            end
            busy_prev = busy;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 64'd0, 64'd1);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(2'd0, v); check(v == 0, "R1 control", {32'd0, v}, 64'd0);
        bus_rd(2'd3, v); check(v == 0, "R1 root", {32'd0, v}, 64'd0);
        check(!busy, "R1 busy", {63'd0, busy}, 64'd0);

        // R6 zero operand
        run_op(1'b0, 64'd0, "R6 zero");
        run_op(1'b0, 64'd1, "R3 one");
        run_op(1'b0, 64'd3, "R3 three");
        run_op(1'b0, 64'd4, "R3 four");
        run_op(1'b0, 64'd143, "R3 below square");
        run_op(1'b0, 64'd144, "R3 square");
        run_op(1'b0, 64'h0000_0000_FFFF_FFFF, "R3 max narrow");
        // R4 high word ignored in narrow mode
        run_op(1'b0, 64'hDEAD_BEEF_0000_0051, "R4 masked high");
        run_op(1'b0, 64'hFFFF_FFFF_0000_0000, "R4 masked to zero");
        // R5 wide mode
        run_op(1'b1, 64'hDEAD_BEEF_0000_0051, "R5 wide same arg");
        run_op(1'b1, 64'h0000_0001_0000_0000, "R5 two pow 32");
        run_op(1'b1, 64'h4000_0000_0000_0000, "R5 two pow 62");
        run_op(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R5 all ones");
        run_op(1'b1, 64'hFFFF_FFFE_0000_0001, "R5 square of max root");

        // R9 readback; busy bit not writable
        bus_rd(2'd1, v); check(v == 32'hFFFF_FFFE ? 1'b0 : v == 32'h0000_0001, "R9 arg low", {32'd0, v}, 64'h1);
        bus_rd(2'd2, v); check(v == 32'hFFFF_FFFE, "R9 arg high", {32'd0, v}, 64'hFFFF_FFFE);
        bus_wr(2'd0, 32'h0000_8001);
        exp_q.push_back('{ref_root(64'hFFFF_FFFE_0000_0001), ref_lat(64'hFFFF_FFFE_0000_0001), cyc, "R9 ctrl rewrite"});
        wait_done();
        bus_rd(2'd0, v); check(v == 32'h0000_0001, "R9 control readback", {32'd0, v}, 64'h1);

        // R8 restart while busy, R10 root holds meanwhile
        bus_wr(2'd2, 32'h4000_0000);
        bus_wr(2'd1, 32'h0);
        repeat (5) @(negedge clk);
        bus_rd(2'd3, v); check(v == 32'hFFFF_FFFF, "R10 root held while busy", {32'd0, v}, 64'hFFFF_FFFF);
        bus_wr(2'd1, 32'd169);
        bus_wr(2'd0, 32'd0);
        exp_q.push_back('{32'd13, 6, cyc, "R8 restart"});
        wait_done();
        repeat (40) @(negedge clk);
        check(exp_q.size() == 0 && !busy, "R8 single completion", {63'd0, busy}, 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end

endmodule